// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous fast-page-mode DRAM alive. Leaving reset, it holds every strobe idle for a programmable power-up pause. It then runs a fixed number of warm-up refresh cycles on its own, and only after these does it declare the memory ready for normal traffic. From then on a free-running interval timer adds one owed refresh per period. The block asks the access controller for the memory with a request line and waits for a grant. Once granted, it drives the row strobe and both column strobes itself. Every refresh uses CAS-before-RAS ordering, so the memory's internal row counter chooses the row and no address is driven.

Owed refreshes are counted up to a limit. A granted burst drains them back to back. A refresh that is owed while the count is already at its limit is lost, and the block reports this as a one-clock deadline pulse. A running refresh cycle always completes, even if the grant is withdrawn part-way through. The write-enable and output-enable strobes stay inactive (high) at all times.

All timings are parameters counted in clock cycles:
- `PAUSE_CYC`: power-up pause.
- `WARMUP_CYC`: number of warm-up cycles.
- `INTERVAL_CYC`: refresh interval.
- `MAX_OWED`: limit on owed refreshes.
- `CAS_LEAD_CYC`: column strobes low before the row strobe falls.
- `CAS_HOLD_CYC`: column strobes held low after the row strobe falls.
- `RAS_LOW_CYC`: row strobe low width.
- `PRECH_CYC`: precharge with all strobes high.

One refresh cycle lasts CAS_LEAD_CYC + RAS_LOW_CYC + PRECH_CYC clocks.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst` is high, all four strobes are high, `init_done`, `ref_req`, `ref_active` and `deadline_err` are low. After reset is released, the strobes stay high until the column strobes first fall, which happens at the (PAUSE_CYC+1)-th rising clock edge.
- R2: After the pause, exactly WARMUP_CYC refresh cycles run back to back, regardless of `ref_gnt` and with `ref_req` low. `init_done` rises one clock after the last warm-up precharge ends, and then stays high until reset.
- R3: Within a refresh cycle, `dram_cas_lo_n` and `dram_cas_hi_n` are always equal. They fall CAS_LEAD_CYC clocks before `dram_ras_n` falls and rise CAS_HOLD_CYC clocks after it falls, while the row strobe is still low.
- R4: `dram_ras_n` stays low for exactly RAS_LOW_CYC clocks. All strobes then stay high for at least PRECH_CYC clocks before the column strobes fall again. `dram_we_n` and `dram_oe_n` are high in every cycle.
- R5: Once `init_done` is high, one refresh becomes owed every INTERVAL_CYC clocks. The first is owed INTERVAL_CYC clocks after `init_done` rises. `ref_req` is high exactly while `init_done` is high and either a refresh is owed or a refresh cycle is running.
- R6: After initialisation, a refresh cycle starts only at a clock edge where `ref_gnt` is high, some refresh is owed, and the sequencer is idle or in the last precharge clock of a cycle. While the grant stays high, owed refreshes are therefore issued back to back with no idle gap.
- R7: Lowering `ref_gnt` never shortens a running refresh cycle. The cycle completes, and no further cycle starts until the grant returns.
- R8: The owed count never exceeds MAX_OWED. If a refresh becomes owed while the count is at MAX_OWED and no cycle starts at that edge, the extra refresh is dropped and `deadline_err` is high for exactly the following clock.
- R9: `ref_active` is high exactly during the clocks of a refresh cycle (column lead, row low and precharge), covering every clock in which any strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller grants the memory to the refresh scheduler |
| ref_req | output | 1 | Refresh scheduler requests the memory |
| ref_active | output | 1 | A refresh cycle is running and the strobes are driven by this block |
| dram_ras_n | output | 1 | Row address strobe, active low |
| dram_cas_lo_n | output | 1 | Lower-byte column address strobe, active low |
| dram_cas_hi_n | output | 1 | Upper-byte column address strobe, active low |
| dram_we_n | output | 1 | Write enable, held high |
| dram_oe_n | output | 1 | Output enable, held high |
| init_done | output | 1 | Power-up pause and warm-up refreshes are finished |
| deadline_err | output | 1 | One-clock pulse when an owed refresh is dropped at the limit |

## Verification
The bench builds the scheduler with the following parameters:
- a 20-clock pause and the full 8 warm-up cycles;
- a 40-clock interval and an owed limit of 3;
- timings of 2, 2, 4 and 3 clocks, which give a 9-clock refresh cycle.

With these values, the whole initialisation fits in under a hundred clocks. Several refresh periods also fit in a few hundred clocks. Withholding the grant for five periods is then enough to drive the owed count into saturation and to produce dropped-refresh pulses. The back-to-back drain that follows, and a grant withdrawn in the middle of a cycle, are likewise brief enough to be compared against the reference model on every clock.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_CAS_LEAD  = 2'd1,
        SEQ_RAS_LOW   = 2'd2,
        SEQ_PRECHARGE = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE  = 2'd0,
        PH_WARMUP = 2'd1,
        PH_READY  = 2'd2
    } init_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic busy;
    } strobe_t;

    // bits needed for a counter running 0 .. limit-1
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

    // bits needed to hold 0 .. limit
    function automatic int val_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cbr_refresh_interval.sv
module cbr_refresh_interval
    import cbr_refresh_pkg::*;
#(
    parameter int INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = cnt_width(INTERVAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/cbr_refresh_owed.sv
module cbr_refresh_owed
    import cbr_refresh_pkg::*;
#(
    parameter int MAX_OWED = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic                             take,
    output logic [val_width(MAX_OWED)-1:0]   owed,
    output logic                             owed_nz,
    output logic                             overflow
);
    localparam int OW = val_width(MAX_OWED);
    localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

    logic [OW-1:0] owed_q;
    logic [OW-1:0] owed_d;
    logic          full;
    logic          accept;
    logic          ovf_q;

    assign full   = (owed_q == FULL);
    assign accept = tick && (!full || take);

    always_comb begin
        owed_d = owed_q;
        if (accept && !take) begin
            owed_d = owed_q + OW'(1);
        end else if (!accept && take) begin
            owed_d = owed_q - OW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            owed_q <= owed_d;
            ovf_q  <= tick && full && !take;
        end
    end

    assign owed     = owed_q;
    assign owed_nz  = (owed_q != '0);
    assign overflow = ovf_q;

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
    import cbr_refresh_pkg::*;
#(
    parameter int CAS_LEAD_CYC = 2,
    parameter int CAS_HOLD_CYC = 2,
    parameter int RAS_LOW_CYC  = 16,
    parameter int PRECH_CYC    = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    output logic    taken,
    output logic    idle,
    output strobe_t strb
);
    localparam int LONGEST = max3(CAS_LEAD_CYC, RAS_LOW_CYC, PRECH_CYC);
    localparam int CW      = cnt_width(LONGEST);
    localparam logic [CW-1:0] LEAD_LAST = CW'(CAS_LEAD_CYC - 1);
    localparam logic [CW-1:0] RAS_LAST  = CW'(RAS_LOW_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRECH_CYC - 1);
    localparam logic [CW-1:0] HOLD_END  = CW'(CAS_HOLD_CYC);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          last;
    logic          free;

    always_comb begin
        case (state_q)
            SEQ_CAS_LEAD:  last = (cnt_q == LEAD_LAST);
            SEQ_RAS_LOW:   last = (cnt_q == RAS_LAST);
            SEQ_PRECHARGE: last = (cnt_q == PRE_LAST);
            default:       last = 1'b0;
        endcase
    end

    assign free  = (state_q == SEQ_IDLE) || ((state_q == SEQ_PRECHARGE) && last);
    assign taken = free && go;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (taken) begin
            state_d = SEQ_CAS_LEAD;
            cnt_d   = '0;
        end else if (state_q != SEQ_IDLE) begin
            if (last) begin
                cnt_d = '0;
                case (state_q)
                    SEQ_CAS_LEAD: state_d = SEQ_RAS_LOW;
                    SEQ_RAS_LOW:  state_d = SEQ_PRECHARGE;
                    default:      state_d = SEQ_IDLE;
                endcase
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // strobe decode from the phase registers
    always_comb begin
        strb.busy  = (state_q != SEQ_IDLE);
        strb.ras_n = (state_q != SEQ_RAS_LOW);
        strb.cas_n = !((state_q == SEQ_CAS_LEAD) ||
                       ((state_q == SEQ_RAS_LOW) && (cnt_q < HOLD_END)));
    end

    assign idle = (state_q == SEQ_IDLE);

endmodule

// File: rtl/cbr_refresh_init.sv
module cbr_refresh_init
    import cbr_refresh_pkg::*;
#(
    parameter int PAUSE_CYC  = 40000,
    parameter int WARMUP_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seq_idle,
    input  logic        started,
    output init_phase_e phase,
    output logic        warm_go
);
    localparam int PW = cnt_width(PAUSE_CYC);
    localparam int WW = val_width(WARMUP_CYC);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [WW-1:0] WARM_ALL   = WW'(WARMUP_CYC);

    init_phase_e   phase_q;
    logic [PW-1:0] pause_q;
    logic [WW-1:0] warm_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_PAUSE;
            pause_q     <= '0;
            warm_left_q <= WARM_ALL;
        end else begin
            case (phase_q)
                PH_PAUSE: begin
                    if (pause_q == PAUSE_LAST) begin
                        phase_q <= PH_WARMUP;
                    end else begin
                        pause_q <= pause_q + PW'(1);
                    end
                end
                PH_WARMUP: begin
                    if (started) begin
                        warm_left_q <= warm_left_q - WW'(1);
                    end
                    if ((warm_left_q == '0) && seq_idle) begin
                        phase_q <= PH_READY;
                    end
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    assign phase   = phase_q;
    assign warm_go = (phase_q == PH_WARMUP) && (warm_left_q != '0);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_refresh_pkg::*;
#(
    parameter int PAUSE_CYC    = 40000,
    parameter int WARMUP_CYC   = 8,
    parameter int INTERVAL_CYC = 3120,
    parameter int MAX_OWED     = 4,
    parameter int CAS_LEAD_CYC = 2,
    parameter int CAS_HOLD_CYC = 2,
    parameter int RAS_LOW_CYC  = 16,
    parameter int PRECH_CYC    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_active,
    output logic dram_ras_n,
    output logic dram_cas_lo_n,
    output logic dram_cas_hi_n,
    output logic dram_we_n,
    output logic dram_oe_n,
    output logic init_done,
    output logic deadline_err
);
    localparam int OW = val_width(MAX_OWED);

    init_phase_e   phase;
    strobe_t       strb;
    logic          warm_go;
    logic          ready;
    logic          tick;
    logic          go;
    logic          taken;
    logic          take_owed;
    logic          seq_idle;
    logic          owed_nz;
    logic [OW-1:0] owed_cnt;

    cbr_refresh_init #(
        .PAUSE_CYC  (PAUSE_CYC),
        .WARMUP_CYC (WARMUP_CYC)
    ) u_init (
        .clk      (clk),
        .rst      (rst),
        .seq_idle (seq_idle),
        .started  (taken),
        .phase    (phase),
        .warm_go  (warm_go)
    );

    assign ready = (phase == PH_READY);

    cbr_refresh_interval #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (ready),
        .tick (tick)
    );

    assign take_owed = taken && ready;

    cbr_refresh_owed #(
        .MAX_OWED (MAX_OWED)
    ) u_owed (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .take     (take_owed),
        .owed     (owed_cnt),
        .owed_nz  (owed_nz),
        .overflow (deadline_err)
    );

    // warm-up runs unattended; afterwards a grant and an owed refresh are needed
    assign go = warm_go || (ready && ref_gnt && owed_nz);

    cbr_refresh_seq #(
        .CAS_LEAD_CYC (CAS_LEAD_CYC),
        .CAS_HOLD_CYC (CAS_HOLD_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .PRECH_CYC    (PRECH_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .taken (taken),
        .idle  (seq_idle),
        .strb  (strb)
    );

    assign ref_req       = ready && (owed_nz || !seq_idle);
    assign ref_active    = strb.busy;
    assign dram_ras_n    = strb.ras_n;
    assign dram_cas_lo_n = strb.cas_n;
    assign dram_cas_hi_n = strb.cas_n;
    assign dram_we_n     = 1'b1;
    assign dram_oe_n     = 1'b1;
    assign init_done     = ready;

endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk
    import cbr_refresh_pkg::*;
#(
    parameter int PAUSE_CYC    = 40000,
    parameter int MAX_OWED     = 4,
    parameter int CAS_LEAD_CYC = 2,
    parameter int PRECH_CYC    = 10
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           ref_gnt,
    input logic                           ref_active,
    input logic                           dram_ras_n,
    input logic                           dram_cas_lo_n,
    input logic                           init_done,
    input logic                           deadline_err,
    input logic [val_width(MAX_OWED)-1:0] owed_cnt
);
    localparam int SW     = val_width(PAUSE_CYC + 1);
    localparam int HSAT   = PRECH_CYC + CAS_LEAD_CYC;
    localparam int HW     = val_width(HSAT);

    logic [SW-1:0] since_rst;
    logic [HW-1:0] ras_hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst  <= '0;
            ras_hi_run <= HW'(HSAT);
        end else begin
            if (since_rst != SW'(PAUSE_CYC + 1)) begin
                since_rst <= since_rst + SW'(1);
            end
            if (!dram_ras_n) begin
                ras_hi_run <= '0;
            end else if (ras_hi_run != HW'(HSAT)) begin
                ras_hi_run <= ras_hi_run + HW'(1);
            end
        end
    end

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (int'(since_rst) <= PAUSE_CYC) |-> (dram_ras_n && dram_cas_lo_n)); // R1

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R2

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (!dram_cas_lo_n && $past(!dram_cas_lo_n))); // R3

    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (int'(ras_hi_run) >= PRECH_CYC)); // R4

    AST_START_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_lo_n) && $past(init_done)) |-> $past(ref_gnt)); // R6

    AST_OWED_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(owed_cnt) <= MAX_OWED); // R8

    AST_DEADLINE_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        deadline_err |-> init_done); // R8

    AST_ACTIVE_COVERS_RAS: assert property (@(posedge clk) disable iff (rst)
        !dram_ras_n |-> ref_active); // R9

endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
    .PAUSE_CYC    (PAUSE_CYC),
    .MAX_OWED     (MAX_OWED),
    .CAS_LEAD_CYC (CAS_LEAD_CYC),
    .PRECH_CYC    (PRECH_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ref_gnt       (ref_gnt),
    .ref_active    (ref_active),
    .dram_ras_n    (dram_ras_n),
    .dram_cas_lo_n (dram_cas_lo_n),
    .init_done     (init_done),
    .deadline_err  (deadline_err),
    .owed_cnt      (owed_cnt)
);

// File: tb/cbr_refresh_sched_tb.sv
module cbr_refresh_sched_tb;
    localparam int P_PAUSE = 20;
    localparam int P_WARM  = 8;
    localparam int P_INT   = 40;
    localparam int P_MAX   = 3;
    localparam int P_LEAD  = 2;
    localparam int P_HOLD  = 2;
    localparam int P_RAS   = 4;
    localparam int P_PRE   = 3;
    localparam int CYC     = P_LEAD + P_RAS + P_PRE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_active, dram_ras_n, dram_cas_lo_n, dram_cas_hi_n;
    logic dram_we_n, dram_oe_n, init_done, deadline_err;

    always #2.5 clk = ~clk;

    cbr_refresh_sched #(
        .PAUSE_CYC(P_PAUSE), .WARMUP_CYC(P_WARM), .INTERVAL_CYC(P_INT),
        .MAX_OWED(P_MAX), .CAS_LEAD_CYC(P_LEAD), .CAS_HOLD_CYC(P_HOLD),
        .RAS_LOW_CYC(P_RAS), .PRECH_CYC(P_PRE)
    ) u_dut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ref_active(ref_active), .dram_ras_n(dram_ras_n),
        .dram_cas_lo_n(dram_cas_lo_n), .dram_cas_hi_n(dram_cas_hi_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .init_done(init_done), .deadline_err(deadline_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_since, m_phase, m_warm, m_tmr, m_owed, m_pos;
    bit m_busy, m_err;

    always @(posedge clk) begin
        if (rst) begin
            m_since = 0; m_phase = 0; m_warm = P_WARM; m_tmr = 0;
            m_owed = 0; m_pos = 0; m_busy = 0; m_err = 0;
        end else begin
            bit cyc_end, free, rdy, tk, go, take, was_busy;
            int wl;
            was_busy = m_busy;
            wl       = m_warm;
            cyc_end  = m_busy && (m_pos == CYC - 1);
            free     = !m_busy || cyc_end;
            rdy      = (m_phase == 2);
            tk       = rdy && (m_tmr == P_INT - 1);
            go       = ((m_phase == 1) && (m_warm > 0)) || (rdy && ref_gnt && (m_owed > 0));
            take     = free && go;
            m_err    = tk && (m_owed == P_MAX) && !take;
            if (rdy) begin
                m_owed = m_owed + (tk ? 1 : 0) - (take ? 1 : 0);
                if (m_owed > P_MAX) m_owed = P_MAX;
                m_tmr = tk ? 0 : m_tmr + 1;
            end
            if (m_phase == 0) begin
                if (m_since == P_PAUSE - 1) m_phase = 1; else m_since++;
            end else if (m_phase == 1) begin
                if (take) m_warm--;
                if (wl == 0 && !was_busy) begin m_phase = 2; m_tmr = 0; end
            end
            if (take) begin m_busy = 1; m_pos = 0; end
            else if (m_busy) begin
                if (cyc_end) m_busy = 0; else m_pos++;
            end
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int  edges = 0;
    int  first_cas_fall = -1;
    int  warm_ras_falls = 0;
    int  err_pulses = 0;
    int  act_run = 0;
    int  max_run = 0;
    int  last_ras_fall = -1;
    int  ras_gap = 0;
    int  cas_low_run = 0;
    bit  prev_cas = 1'b1, prev_ras = 1'b1;

    always @(posedge clk) if (!rst) edges++; else edges = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit e_cas, e_ras, e_done;
            e_cas  = !(m_busy && (m_pos < P_LEAD + P_HOLD));
            e_ras  = !(m_busy && (m_pos >= P_LEAD) && (m_pos < P_LEAD + P_RAS));
            e_done = (m_phase == 2);
            check(dram_cas_lo_n == e_cas, "R3", "cas_lo_n", dram_cas_lo_n, e_cas);
            check(dram_cas_hi_n == dram_cas_lo_n, "R3", "cas_hi_n pairing", dram_cas_hi_n, dram_cas_lo_n);
            check(dram_ras_n == e_ras, "R4", "ras_n", dram_ras_n, e_ras);
            check(dram_we_n && dram_oe_n, "R4", "we_n&oe_n", dram_we_n & dram_oe_n, 1);
            check(init_done == e_done, "R2", "init_done", init_done, e_done);
            check(ref_req == (e_done && (m_owed > 0 || m_busy)), "R5", "ref_req", ref_req,
                  e_done && (m_owed > 0 || m_busy));
            check(ref_active == m_busy, "R9", "ref_active", ref_active, m_busy);
            check(deadline_err == m_err, "R8", "deadline_err", deadline_err, m_err);
            // independent protocol monitors
            if (prev_cas && !dram_cas_lo_n && first_cas_fall < 0) first_cas_fall = edges;
            if (prev_ras && !dram_ras_n) begin
                check(cas_low_run == P_LEAD, "R3", "cas lead before ras fall", cas_low_run, P_LEAD);
                if (!init_done) warm_ras_falls++;
                else begin
                    if (last_ras_fall >= 0) ras_gap = edges - last_ras_fall;
                    last_ras_fall = edges;
                end
            end
            cas_low_run = dram_cas_lo_n ? 0 : cas_low_run + 1;
            if (deadline_err) err_pulses++;
            act_run = ref_active ? act_run + 1 : 0;
            if (act_run > max_run) max_run = act_run;
            prev_cas = dram_cas_lo_n;
            prev_ras = dram_ras_n;
        end
    end

    // grant driver: 0 never, 1 follows request after two clocks, 2 always
    int gmode = 0;
    bit req_d1 = 0, req_d2 = 0;
    always @(negedge clk) begin
        req_d2 <= req_d1;
        req_d1 <= ref_req;
        ref_gnt <= (gmode == 2) ? 1'b1 : (gmode == 1) ? req_d2 : 1'b0;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_lo_n && dram_cas_hi_n, "R1", "strobes in reset",
              {dram_ras_n, dram_cas_lo_n, dram_cas_hi_n}, 7);
        check(!init_done && !ref_req && !ref_active && !deadline_err, "R1", "flags in reset",
              {init_done, ref_req, ref_active, deadline_err}, 0);
        rst = 1'b0;

        // initialisation without any grant
        wait (init_done);
        @(negedge clk);
        check(first_cas_fall == P_PAUSE + 1, "R1", "first cas fall edge", first_cas_fall, P_PAUSE + 1);
        check(warm_ras_falls == P_WARM, "R2", "warm-up cycle count", warm_ras_falls, P_WARM);

        // steady servicing with a responsive controller
        gmode = 1;
        repeat (300) @(negedge clk);
        check(ras_gap == P_INT, "R5", "refresh spacing", ras_gap, P_INT);

        // withhold grant for five periods: owed count saturates
        gmode = 0;
        err_pulses = 0;
        repeat (5 * P_INT) @(negedge clk);
        check(err_pulses >= 1, "R8", "dropped-refresh pulses", err_pulses, 2);

        // grant held: owed refreshes drain back to back
        max_run = 0;
        gmode = 2;
        repeat (4 * CYC + 5) @(negedge clk);
        check(max_run >= P_MAX * CYC, "R6", "back-to-back active run", max_run, P_MAX * CYC);

        // grant withdrawn in the middle of a cycle
        gmode = 1;
        wait (!ref_active);
        @(negedge clk);
        wait (ref_active);
        @(negedge clk);
        @(negedge clk);
        gmode = 0;
        max_run = 0;
        repeat (CYC + 6) @(negedge clk);
        check(max_run == CYC, "R7", "cycle completes after grant drop", max_run, CYC);

        gmode = 1;
        repeat (100) @(negedge clk);
        summary();
        $finish;
    end

endmodule